// File: doc/BRIEF.md
# GPIO Interrupt Aggregator with Per-CPU Masking

This block is the interrupt front end of a GPIO bank. It takes the input vector after polarity adjustment (supplied by the neighbouring pin block) and derives two kinds of cause per line:

- A level cause, taken directly from the current input.
- An edge cause, latched when the input goes from 0 to 1 and held until software clears it.

Each CPU owns an edge-enable mask and a level-enable mask. A line is pending for a CPU when it has an enabled level cause or an enabled edge cause. The pending lines of each group of eight are ORed into one summary interrupt line for that CPU. Software identifies the individual line by reading the cause and mask registers.

The parameter `NCPU` (1, 2 or 4) selects how many mask sets exist and which register map applies. With 1 or 2 CPUs, one shared edge cause register sits in the main region. With 4 CPUs, every CPU has its own edge cause copy, and all per-CPU registers sit in a separate region selected by `bus_pcpu`.

Edge detection is governed by a two-state controller:

- After reset it is in `ST_PRIME`. For one clock it only records the input, so an input that is already high is not mistaken for an edge.
- It then moves to `ST_ARMED` and stays there until the next reset.

Top module: `gpio_irq_agg`

## Requirements
- R1: During and after reset every cause and mask register reads 0 and every `irq_o` bit is low.
- R2: The level cause of line i is `line_in[i] & lmask[i]`. It is combinational and not latched: it falls as soon as the input falls.
- R3: A 0-to-1 change of `line_in[i]` sets edge cause bit i at the next clock edge. The bit stays set after the input returns low. A 1-to-0 change sets nothing.
- R4: A write to a cause register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R5: If an edge on a line occurs in the same cycle as a write that clears that line's cause bit, the bit ends up set.
- R6: For CPU c, `irq_o[c*4+g]` is the OR over lines 8g..8g+7 of `(line_in & lmask_c) | (cause_c & emask_c)`.
- R7: An input that is already high at reset release produces no edge cause. Edge detection starts one clock after reset release (`ST_PRIME` to `ST_ARMED`).
- R8: With NCPU of 1 or 2, registers are reached with `bus_pcpu`=0:
  - the shared cause at 0x14;
  - the CPU0 edge mask at 0x18 and the CPU0 level mask at 0x1C;
  - the CPU1 edge mask at 0x30 and the CPU1 level mask at 0x34 (2-CPU map only).
- R9: With NCPU=4, registers are reached with `bus_pcpu`=1:
  - the cause of CPU n at 4n;
  - the edge mask of CPU n at 0x10+4n;
  - the level mask of CPU n at 0x20+4n.
- R10: With NCPU=4, an edge sets every CPU's cause copy. A clearing write to one CPU's cause changes only that copy.
- R11: Writes to unmapped addresses change no register, and reads of unmapped addresses return 0. This includes the main region when NCPU=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | NLINES | Polarity-adjusted input lines |
| bus_wr | input | 1 | Register write strobe |
| bus_pcpu | input | 1 | 1 selects the per-CPU region (4-CPU map) |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | NLINES | Write data |
| bus_rdata | output | NLINES | Read data for `bus_addr` (combinational) |
| irq_o | output | NCPU*NLINES/8 | Group summary interrupts; CPU c owns bits c*4..c*4+3 |

## Verification
The bound checker watches CPU0 on every cycle. It checks the following:

- Irq lines are quiet during reset and stay silent while CPU0's masks are zero.
- Every detected edge is present in the cause register one clock later, even when a clear is written in the same cycle.
- A cause bit never rises without an edge.
- A clearing write without a coincident edge leaves exactly the bits written as 1.

Some behaviours can only be shown by the bench's scenarios:

- the address maps of the different CPU counts;
- the independence of the per-CPU cause copies;
- the group-to-output mapping;
- the absence of a false edge at reset release.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W = 8;

    typedef enum logic [1:0] {
        RK_NONE,
        RK_CAUSE,
        RK_EMASK,
        RK_LMASK
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [1:0] idx;
    } reg_sel_t;

    // Map a bus address onto a register kind and CPU index for a given CPU count.
    function automatic reg_sel_t decode_addr(input int ncpu, input logic pcpu,
                                             input logic [ADDR_W-1:0] addr);
        reg_sel_t s;
        s.kind = RK_NONE;
        s.idx  = 2'd0;
        if (ncpu == 4) begin
            if (pcpu && addr[1:0] == 2'b00) begin
                s.idx = addr[3:2];
                case (addr[7:4])
                    4'h0:    s.kind = RK_CAUSE;
                    4'h1:    s.kind = RK_EMASK;
                    4'h2:    s.kind = RK_LMASK;
                    default: s.kind = RK_NONE;
                endcase
            end
        end else if (!pcpu) begin
            case (addr)
                8'h14: s.kind = RK_CAUSE;
                8'h18: s.kind = RK_EMASK;
                8'h1C: s.kind = RK_LMASK;
                8'h30: if (ncpu >= 2) begin s.kind = RK_EMASK; s.idx = 2'd1; end
                8'h34: if (ncpu >= 2) begin s.kind = RK_LMASK; s.idx = 2'd1; end
                default: s.kind = RK_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] line_in,
    output logic [NLINES-1:0] edge_o
);
    typedef enum logic {ST_PRIME, ST_ARMED} det_state_e;

    det_state_e        state_q, state_d;
    logic [NLINES-1:0] prev_q;
    logic              armed;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: state_d = ST_ARMED;
            ST_ARMED: state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
            prev_q  <= '0;
        end else begin
            state_q <= state_d;
            prev_q  <= line_in;
        end
    end

    always_comb begin
        armed  = (state_q == ST_ARMED);
        edge_o = line_in & ~prev_q & {NLINES{armed}};
    end
endmodule

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause #(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_we,
    input  logic [NLINES-1:0] clr_data,
    input  logic [NLINES-1:0] set_vec,
    output logic [NLINES-1:0] cause_o
);
    logic [NLINES-1:0] kept;

    // Zeros in the write data clear; a simultaneous edge re-sets the bit.
    assign kept = clr_we ? (cause_o & clr_data) : cause_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause_o <= '0;
        else        cause_o <= kept | set_vec;
    end
endmodule

// File: rtl/gpio_cpu_masks.sv
module gpio_cpu_masks #(
    parameter int NLINES  = 32,
    parameter int GROUP_W = 8,
    localparam int NGROUP = NLINES / GROUP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              em_we,
    input  logic              lm_we,
    input  logic [NLINES-1:0] wdata,
    input  logic [NLINES-1:0] line_in,
    input  logic [NLINES-1:0] cause_in,
    output logic [NLINES-1:0] em_o,
    output logic [NLINES-1:0] lm_o,
    output logic [NGROUP-1:0] irq_o
);
    logic [NLINES-1:0] pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            em_o <= '0;
            lm_o <= '0;
        end else begin
            if (em_we) em_o <= wdata;
            if (lm_we) lm_o <= wdata;
        end
    end

    assign pending = (line_in & lm_o) | (cause_in & em_o);

    for (genvar g = 0; g < NGROUP; g++) begin : g_grp
        assign irq_o[g] = |pending[g*GROUP_W +: GROUP_W];
    end
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
    import gpio_irq_pkg::*;
#(
    parameter int NCPU    = 4,
    parameter int NLINES  = 32,
    parameter int GROUP_W = 8,
    localparam int NGROUP = NLINES / GROUP_W,
    localparam int NCAUSE = (NCPU == 4) ? NCPU : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NLINES-1:0]        line_in,
    input  logic                     bus_wr,
    input  logic                     bus_pcpu,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [NLINES-1:0]        bus_wdata,
    output logic [NLINES-1:0]        bus_rdata,
    output logic [NCPU*NGROUP-1:0]   irq_o
);
    reg_sel_t                     sel;
    logic [NLINES-1:0]            edge_vec;
    logic [NCAUSE-1:0]            cause_we;
    logic [NCAUSE-1:0][NLINES-1:0] cause_q;
    logic [NCPU-1:0][NLINES-1:0]  em_q;
    logic [NCPU-1:0][NLINES-1:0]  lm_q;

    assign sel = decode_addr(NCPU, bus_pcpu, bus_addr);

    gpio_edge_detect #(.NLINES(NLINES)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .edge_o  (edge_vec)
    );

    for (genvar k = 0; k < NCAUSE; k++) begin : g_cause
        assign cause_we[k] = bus_wr && sel.kind == RK_CAUSE && sel.idx == 2'(k);
        gpio_edge_cause #(.NLINES(NLINES)) u_cause (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_we   (cause_we[k]),
            .clr_data (bus_wdata),
            .set_vec  (edge_vec),
            .cause_o  (cause_q[k])
        );
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        localparam int CI = (NCAUSE == 1) ? 0 : c;
        gpio_cpu_masks #(.NLINES(NLINES), .GROUP_W(GROUP_W)) u_masks (
            .clk      (clk),
            .rst_n    (rst_n),
            .em_we    (bus_wr && sel.kind == RK_EMASK && sel.idx == 2'(c)),
            .lm_we    (bus_wr && sel.kind == RK_LMASK && sel.idx == 2'(c)),
            .wdata    (bus_wdata),
            .line_in  (line_in),
            .cause_in (cause_q[CI]),
            .em_o     (em_q[c]),
            .lm_o     (lm_q[c]),
            .irq_o    (irq_o[c*NGROUP +: NGROUP])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NCAUSE; k++)
            if (sel.kind == RK_CAUSE && sel.idx == 2'(k)) bus_rdata = cause_q[k];
        for (int c = 0; c < NCPU; c++) begin
            if (sel.kind == RK_EMASK && sel.idx == 2'(c)) bus_rdata = em_q[c];
            if (sel.kind == RK_LMASK && sel.idx == 2'(c)) bus_rdata = lm_q[c];
        end
    end
endmodule

// File: rtl/gpio_irq_agg_chk.sv
module gpio_irq_agg_chk #(
    parameter int NLINES = 32,
    parameter int NGROUP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NGROUP-1:0] irq_grp0,
    input logic [NLINES-1:0] edge_vec,
    input logic [NLINES-1:0] cause0,
    input logic              cause_we0,
    input logic [NLINES-1:0] wdata,
    input logic [NLINES-1:0] em0,
    input logic [NLINES-1:0] lm0
);
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (irq_grp0 == '0);
        end
    end

    assert_edge_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_vec != '0) |=> ((cause0 & $past(edge_vec)) == $past(edge_vec)));

    assert_no_spurious_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((cause0 & ~$past(cause0) & ~$past(edge_vec)) == '0));

    assert_clear_zero_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_we0 && edge_vec == '0) |=> (cause0 == $past(cause0 & wdata)));

    assert_masked_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((em0 | lm0) == '0) |-> (irq_grp0 == '0));
endmodule

bind gpio_irq_agg gpio_irq_agg_chk #(.NLINES(NLINES), .NGROUP(NGROUP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_grp0  (irq_o[NGROUP-1:0]),
    .edge_vec  (edge_vec),
    .cause0    (cause_q[0]),
    .cause_we0 (cause_we[0]),
    .wdata     (bus_wdata),
    .em0       (em_q[0]),
    .lm0       (lm_q[0])
);

// File: tb/test_gpio_irq_agg.sv
module test_gpio_irq_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] line_in = 32'h0000_0001;
    logic        bus_wr = 1'b0;
    logic        d_wr = 1'b0;
    logic        bus_pcpu = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [31:0] d_rdata;
    logic [15:0] irq;
    logic [7:0]  irq_d;
    int checks = 0;
    int failures = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    gpio_irq_agg #(.NCPU(4)) i_gpio_irq_agg (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .bus_wr(bus_wr),
        .bus_pcpu(bus_pcpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq));

    gpio_irq_agg #(.NCPU(2)) i_gpio_irq_agg_dual (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .bus_wr(d_wr),
        .bus_pcpu(bus_pcpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(d_rdata), .irq_o(irq_d));

    // Level-mask table for CPU0: {lmask, line_in, expected irq[15:0]}
    localparam logic [79:0] LVL_TAB [6] = '{
        {32'hFFFF_FFFF, 32'h0000_0001, 16'h0001},
        {32'hFFFF_FFFF, 32'h8000_0000, 16'h0008},
        {32'h0000_FF00, 32'h000F_0F0F, 16'h0002},
        {32'h00FF_0000, 32'hFF00_FFFF, 16'h0000},
        {32'hF0F0_F0F0, 32'h1001_1000, 16'h000A},
        {32'h0000_0000, 32'hFFFF_FFFF, 16'h0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic pc, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_pcpu = pc; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic d_write(input logic pc, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_pcpu = pc; bus_addr = a; bus_wdata = d; d_wr = 1'b1;
        @(negedge clk);
        d_wr = 1'b0;
    endtask

    task automatic bus_read(input logic pc, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_pcpu = pc; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic d_read(input logic pc, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_pcpu = pc; bus_addr = a;
        #1 d = d_rdata;
    endtask

    task automatic set_line(input logic [31:0] v);
        @(negedge clk);
        line_in = v;
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 check("R1 irq in reset", {16'h0, irq}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_read(1'b1, 8'h00, rv); check("R7 no edge at reset release", rv, 32'h0);
        bus_read(1'b1, 8'h14, rv); check("R1 emask cpu1 reset", rv, 32'h0);
        bus_read(1'b1, 8'h2C, rv); check("R1 lmask cpu3 reset", rv, 32'h0);
        check("R1 irq after reset", {16'h0, irq}, 32'h0);

        // R2 / R6: level table walk
        for (int i = 0; i < 6; i++) begin
            bus_write(1'b1, 8'h20, LVL_TAB[i][79:48]);
            set_line(LVL_TAB[i][47:16]);
            #1 check($sformatf("R2 level row %0d", i), {16'h0, irq}, {16'h0, LVL_TAB[i][15:0]});
        end

        set_line(32'h0);
        bus_write(1'b1, 8'h20, 32'h0);
        for (int k = 0; k < 4; k++) bus_write(1'b1, 8'(k * 4), 32'h0);
        bus_read(1'b1, 8'h04, rv); check("R4 cleared cause cpu1", rv, 32'h0);

        // R3 edge latch
        bus_write(1'b1, 8'h10, 32'h0000_0100);
        bus_read(1'b1, 8'h10, rv); check("R9 emask cpu0 at 0x10", rv, 32'h0000_0100);
        set_line(32'h0000_0100);
        #1 check("R3 not before clock", {16'h0, irq}, 32'h0);
        @(negedge clk);
        #1 check("R3 edge latched", {16'h0, irq}, 32'h0000_0002);
        set_line(32'h0);
        repeat (2) @(negedge clk);
        #1 check("R3 held after fall", {16'h0, irq}, 32'h0000_0002);
        bus_read(1'b1, 8'h00, rv); check("R3 cause cpu0", rv, 32'h0000_0100);
        bus_read(1'b1, 8'h04, rv); check("R10 cause cpu1 also set", rv, 32'h0000_0100);

        // R10 independent clear
        bus_write(1'b1, 8'h04, 32'hFFFF_FEFF);
        bus_read(1'b1, 8'h04, rv); check("R10 cpu1 cleared", rv, 32'h0);
        bus_read(1'b1, 8'h00, rv); check("R10 cpu0 untouched", rv, 32'h0000_0100);

        // R4 ones keep, zeros clear
        bus_write(1'b1, 8'h00, 32'hFFFF_FFFF);
        bus_read(1'b1, 8'h00, rv); check("R4 ones keep", rv, 32'h0000_0100);
        bus_write(1'b1, 8'h00, 32'hFFFF_FEFF);
        bus_read(1'b1, 8'h00, rv); check("R4 zero clears", rv, 32'h0);
        check("R4 irq dropped", {16'h0, irq}, 32'h0);

        // R5 set wins over clear
        @(negedge clk);
        line_in = 32'h0000_0100;
        bus_pcpu = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h0; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_read(1'b1, 8'h00, rv); check("R5 set wins", rv, 32'h0000_0100);

        // R11 ignored writes in the 4-CPU map
        bus_write(1'b0, 8'h18, 32'hFFFF_FFFF);
        bus_read(1'b1, 8'h10, rv); check("R11 emask unchanged", rv, 32'h0000_0100);
        bus_read(1'b0, 8'h18, rv); check("R11 main region reads 0", rv, 32'h0);
        bus_write(1'b1, 8'h30, 32'hFFFF_FFFF);
        bus_read(1'b1, 8'h30, rv); check("R11 unmapped pcpu reads 0", rv, 32'h0);

        // R6 mixed pending across CPUs and groups
        bus_write(1'b1, 8'h28, 32'h0100_0000);
        set_line(32'h0100_0100);
        #1 check("R6 cpu0 g1 and cpu2 g3", {16'h0, irq}, 32'h0000_0802);
        set_line(32'h0000_0100);
        #1 check("R2 level follows input", {16'h0, irq}, 32'h0000_0002);

        // R8 two-CPU map
        d_write(1'b0, 8'h14, 32'h0);
        d_write(1'b0, 8'h30, 32'h0000_00FF);
        d_read(1'b0, 8'h30, rv); check("R8 cpu1 emask at 0x30", rv, 32'h0000_00FF);
        d_read(1'b0, 8'h18, rv); check("R8 cpu0 emask separate", rv, 32'h0);
        d_write(1'b0, 8'h34, 32'h8000_0000);
        set_line(32'h8000_0100);
        #1 check("R8 cpu1 lmask at 0x34", {24'h0, irq_d}, 32'h0000_0080);
        d_read(1'b0, 8'h14, rv); check("R8 shared cause at 0x14", rv, 32'h8000_0000);
        d_write(1'b0, 8'h20, 32'hFFFF_FFFF);
        d_read(1'b0, 8'h20, rv); check("R11 dual unmapped reads 0", rv, 32'h0);
        #1 check("R11 dual irq unchanged", {24'h0, irq_d}, 32'h0000_0080);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule